// File: doc/BRIEF.md
# EPROM Pulse-Verify Programming Sequencer

This block is a synchronous controller that burns a byte-wide image into an external 8-bit-wide, UV-erasable or one-time-programmable memory. It walks the address space in ascending order. At each address it first reads the current contents. A byte that already matches costs no pulses. A byte that would need a bit raised from 0 to 1 is rejected at once. Any other byte receives program pulses of fixed width, and the location is read back after each pulse. Pulsing stops when the byte matches or when the pulse budget for that address is spent.

Every step of the pulse phase runs with the raised supply and the program voltage enabled. After the last address both enables drop and the whole array is read back with normal read strobes. The image comes from a source port indexed by the address bus. The pulse width comes from the clock-rate parameter, so the same RTL serves any clock. A failure stops the sequencer, records the failing address, and leaves the pulse count visible.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset and whenever not busy, ce_pgm_n and oe_n are 1, vpp_en, vcc_hi_en and mem_drive are 0, and busy, done, fail and bad_byte are 0 after reset.
- R2: Each program pulse holds ce_pgm_n low for exactly CLK_HZ/10000 cycles (100 µs), with oe_n high, mem_drive high, and vpp_en and vcc_hi_en both 1.
- R3: After every pulse the location is read with oe_n low, ce_pgm_n high and vpp_en 1. Pulses are repeated until the read byte equals the source byte, so each address gets exactly as many pulses as it needs, and the memory ends up holding the image.
- R4: A location whose current contents already equal the source byte receives zero pulses.
- R5: When MAX_PULSES pulses at one address still do not produce a match, fail goes to 1, fail_addr holds that address, pulse_cnt reads MAX_PULSES, and no later address is pulsed.
- R6: If the source byte has a 1 in a bit position where the current contents read 0, bad_byte and fail go to 1, fail_addr holds that address, no pulse is spent there, and the sequencer stops.
- R7: Pulses visit addresses in strictly ascending order from 0 to 2^AW−1, and vcc_hi_en stays 1 for the whole pulse phase.
- R8: After the last address, every location is read again with vcc_hi_en and vpp_en at 0 and both ce_pgm_n and oe_n low. The first mismatch sets fail with fail_addr at that address.
- R9: mem_drive is 1 only while oe_n is 1, and it is already 0 in the cycle before any falling edge of oe_n.
- R10: busy is 1 from the cycle after start until the run ends. done goes to 1 only after a run with no failure, and it stays 1 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the sequencer is not busy |
| src_data | input | 8 | Image byte for the address on mem_addr |
| mem_addr | output | AW | Memory address; also indexes the image source |
| mem_wdata | output | 8 | Byte driven onto the memory data pins |
| mem_drive | output | 1 | Output enable for the data pin drivers |
| mem_rdata | input | 8 | Byte read from the memory data pins |
| ce_pgm_n | output | 1 | Active-low chip-enable / program strobe |
| oe_n | output | 1 | Active-low output enable |
| vpp_en | output | 1 | Program voltage enable |
| vcc_hi_en | output | 1 | Raised supply enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished without failure |
| fail | output | 1 | Last run stopped on a failure |
| bad_byte | output | 1 | Failure was a 0-to-1 request |
| fail_addr | output | AW | Address of the failure |
| pulse_cnt | output | PCW | Pulses applied at the current address |

## Verification
The bound checker watches, on every cycle, the strobe and supply combinations that only program and read modes may use. It also checks the data-bus release ahead of output enable, the ascending address order during the pulse phase, the pulse-count bound, and the exclusivity of the status flags. Only the bench scenarios can show the outcomes that depend on memory behaviour. These are the exact number of pulses each address receives, the zero-pulse skip, the stop on pulse exhaustion and on a 0-to-1 request, and a marginal cell that reads correctly at the raised supply but fails the final read at normal supply. The bench models the memory with per-location pulse demands for this purpose.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int AW         = 19,
  parameter int CLK_HZ     = 125_000_000,
  parameter int MAX_PULSES = 25,
  parameter int RD_CYC     = 3,
  localparam int PCW       = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    src_data,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_drive,
  input  logic [7:0]    mem_rdata,
  output logic          ce_pgm_n,
  output logic          oe_n,
  output logic          vpp_en,
  output logic          vcc_hi_en,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          bad_byte,
  output logic [AW-1:0] fail_addr,
  output logic [PCW-1:0] pulse_cnt
);
  localparam int PULSE_CYC = CLK_HZ / 10000;
  localparam int TW = $clog2(PULSE_CYC + RD_CYC + 1);
  localparam logic [AW-1:0] LAST = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_SETUP, S_PULSE, S_REL, S_VFY, S_FV, S_DONE, S_FAIL
  } st_t;

  st_t            st;
  logic [AW-1:0]  addr, faddr;
  logic [TW-1:0]  tmr;
  logic [PCW-1:0] pcnt;
  logic           fail_r, bad_r;

  wire rd_last  = tmr == TW'(RD_CYC - 1);
  wire pul_last = tmr == TW'(PULSE_CYC - 1);
  wire at_last  = addr == LAST;
  wire match    = mem_rdata == src_data;
  wire raise    = |(src_data & ~mem_rdata);
  wire pgm_ph   = st inside {S_CHK, S_SETUP, S_PULSE, S_REL, S_VFY};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; faddr <= '0; tmr <= '0; pcnt <= '0;
      fail_r <= 1'b0; bad_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            st <= S_CHK; addr <= '0; faddr <= '0; tmr <= '0; pcnt <= '0;
            fail_r <= 1'b0; bad_r <= 1'b0;
          end
        S_CHK, S_VFY:
          if (!rd_last) tmr <= tmr + TW'(1);
          else begin
            tmr <= '0;
            if (st == S_CHK && raise) begin
              bad_r <= 1'b1; fail_r <= 1'b1; faddr <= addr; st <= S_FAIL;
            end else if (match) begin
              pcnt <= '0;
              if (at_last) begin addr <= '0; st <= S_FV; end
              else begin addr <= addr + AW'(1); st <= S_CHK; end
            end else if (st == S_VFY && pcnt == PCW'(MAX_PULSES)) begin
              fail_r <= 1'b1; faddr <= addr; st <= S_FAIL;
            end else st <= S_SETUP;
          end
        S_SETUP: begin
          pcnt <= pcnt + PCW'(1); tmr <= '0; st <= S_PULSE;
        end
        S_PULSE:
          if (pul_last) begin tmr <= '0; st <= S_REL; end
          else tmr <= tmr + TW'(1);
        S_REL: st <= S_VFY;
        S_FV:
          if (!rd_last) tmr <= tmr + TW'(1);
          else begin
            tmr <= '0;
            if (!match) begin fail_r <= 1'b1; faddr <= addr; st <= S_FAIL; end
            else if (at_last) st <= S_DONE;
            else addr <= addr + AW'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr;
  assign mem_drive = st == S_SETUP || st == S_PULSE;
  assign mem_wdata = mem_drive ? src_data : 8'h00;
  assign ce_pgm_n  = !(st == S_PULSE || st == S_FV);
  assign oe_n      = !(st == S_CHK || st == S_VFY || st == S_FV);
  assign vpp_en    = pgm_ph;
  assign vcc_hi_en = pgm_ph;
  assign busy      = !(st inside {S_IDLE, S_DONE, S_FAIL});
  assign done      = st == S_DONE;
  assign fail      = fail_r;
  assign bad_byte  = bad_r;
  assign fail_addr = faddr;
  assign pulse_cnt = pcnt;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int AW = 19,
  parameter int PCW = 5,
  parameter int MAX_PULSES = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_drive,
  input logic           ce_pgm_n,
  input logic           oe_n,
  input logic           vpp_en,
  input logic           vcc_hi_en,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input logic           bad_byte,
  input logic [PCW-1:0] pulse_cnt
);
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> oe_n);

  a_r9_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(mem_drive));

  a_r2_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_pgm_n && oe_n) |-> (mem_drive && vpp_en && vcc_hi_en));

  a_r8_final_read_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_pgm_n && !oe_n) |-> (!vpp_en && !vcc_hi_en));

  a_r3_verify_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pgm_n && !oe_n) |-> vpp_en);

  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PCW'(MAX_PULSES));

  a_r7_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_hi_en && $past(vcc_hi_en) && mem_addr != $past(mem_addr))
      |-> mem_addr == $past(mem_addr) + AW'(1));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_pgm_n && oe_n && !vpp_en && !vcc_hi_en && !mem_drive));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done) && !(done && fail));

  a_r6_bad_implies_fail: assert property (@(posedge clk) disable iff (!rst_n)
    bad_byte |-> fail);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.AW(AW), .PCW(PCW), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_drive(mem_drive),
  .ce_pgm_n(ce_pgm_n), .oe_n(oe_n), .vpp_en(vpp_en), .vcc_hi_en(vcc_hi_en),
  .busy(busy), .done(done), .fail(fail), .bad_byte(bad_byte), .pulse_cnt(pulse_cnt)
);

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;
  localparam int AW = 3;
  localparam int N = 1 << AW;
  localparam int CLK_HZ = 200_000;
  localparam int PCYC = CLK_HZ / 10000;
  localparam int MAXP = 4;
  localparam int PCW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, load_req = 1'b0;
  logic [7:0] src_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_drive, ce_pgm_n, oe_n, vpp_en, vcc_hi_en, busy, done, fail, bad_byte;
  logic [PCW-1:0] pulse_cnt;

  logic [7:0] image [N];
  logic [7:0] init_img [N];
  logic [7:0] weak_img [N];
  logic [7:0] arr [N];
  int need [N];
  int hits [N];
  int exp_q [$];

  int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0;
  int modebad = 0, contention = 0, lowcnt = 0, pa = 0;
  logic [7:0] wd = 8'h00;

  always #4 clk = ~clk;

  assign src_data  = image[mem_addr];
  assign mem_rdata = !oe_n ? (arr[mem_addr] ^ (vcc_hi_en ? 8'h00 : weak_img[mem_addr])) : 8'hFF;

  eprom_prog_seq #(.AW(AW), .CLK_HZ(CLK_HZ), .MAX_PULSES(MAXP), .RD_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
    .mem_rdata(mem_rdata), .ce_pgm_n(ce_pgm_n), .oe_n(oe_n), .vpp_en(vpp_en),
    .vcc_hi_en(vcc_hi_en), .busy(busy), .done(done), .fail(fail),
    .bad_byte(bad_byte), .fail_addr(fail_addr), .pulse_cnt(pulse_cnt)
  );

  // memory model and pulse monitor (scoreboard consumer)
  always @(negedge clk) begin
    if (load_req) begin
      for (int i = 0; i < N; i++) begin arr[i] = init_img[i]; hits[i] = 0; end
      lowcnt = 0;
    end
    if (mem_drive && !oe_n) contention++;
    if (!ce_pgm_n && oe_n) begin
      lowcnt++;
      wd = mem_wdata;
      pa = int'(mem_addr);
      if (!(vpp_en && vcc_hi_en && mem_drive)) modebad++;
    end else if (lowcnt != 0) begin
      hits[pa]++;
      if (hits[pa] >= need[pa]) arr[pa] = arr[pa] & wd;
      mon_chk++;
      if (lowcnt != PCYC) begin
        mon_bad++;
        $display("FAIL R2 pulse width: actual %0d expected %0d", lowcnt, PCYC);
      end
      mon_chk++;
      if (exp_q.size() == 0) begin
        mon_bad++;
        $display("FAIL R3 unexpected pulse: actual addr %0d expected none", pa);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != pa) begin
          mon_bad++;
          $display("FAIL R7 pulse order: actual addr %0d expected %0d", pa, e);
        end
      end
      lowcnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic base_setup();
    image[0] = 8'h00; image[1] = 8'h5A; image[2] = 8'hFF; image[3] = 8'h81;
    image[4] = 8'h3C; image[5] = 8'hFE; image[6] = 8'h7F; image[7] = 8'hA5;
    for (int i = 0; i < N; i++) begin
      init_img[i] = 8'hFF; weak_img[i] = 8'h00; need[i] = 1;
    end
  endtask

  task automatic push_pulses(input int a, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(a);
  endtask

  task automatic run_once(input string tag);
    int m0, c0, k;
    m0 = modebad; c0 = contention;
    @(posedge clk); load_req = 1'b1;
    @(posedge clk); load_req = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {"R10 busy after start ", tag}, int'(busy), 1);
    k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
    check(k < 20000, {"R10 watchdog ", tag}, k, 20000);
    check(exp_q.size() == 0, {"R3 pulses left unissued ", tag}, exp_q.size(), 0);
    exp_q.delete();
    check(modebad == m0, {"R2 pulse strobe mode ", tag}, modebad - m0, 0);
    check(contention == c0, {"R9 bus contention ", tag}, contention - c0, 0);
    check(!vpp_en && !vcc_hi_en && ce_pgm_n && oe_n && !mem_drive,
          {"R1 idle strobes ", tag}, {vpp_en, vcc_hi_en, ce_pgm_n, oe_n, mem_drive}, 5'b00110);
  endtask

  initial begin
    base_setup();
    for (int i = 0; i < N; i++) begin arr[i] = 8'hFF; hits[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail && !bad_byte, "R1 reset flags", {busy, done, fail, bad_byte}, 0);
    check(ce_pgm_n && oe_n && !vpp_en && !vcc_hi_en && !mem_drive, "R1 reset strobes",
          {ce_pgm_n, oe_n, vpp_en, vcc_hi_en, mem_drive}, 5'b11000);

    // A: variable pulse demand, one byte already erased-equal, one at the limit
    base_setup();
    need[1] = 2; need[3] = 3; need[5] = MAXP; need[6] = 2;
    push_pulses(0, 1); push_pulses(1, 2); push_pulses(3, 3); push_pulses(4, 1);
    push_pulses(5, MAXP); push_pulses(6, 2); push_pulses(7, 1);
    run_once("A");
    check(done && !fail && !bad_byte, "R10 done after clean run", {done, fail, bad_byte}, 3'b100);
    for (int i = 0; i < N; i++)
      check(arr[i] == image[i], "R3 image programmed", arr[i], image[i]);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R10 done held", done, 1);

    // B: pulse limit exceeded at address 5
    base_setup();
    need[1] = 2; need[3] = 3; need[5] = MAXP + 1;
    push_pulses(0, 1); push_pulses(1, 2); push_pulses(3, 3); push_pulses(4, 1);
    push_pulses(5, MAXP);
    run_once("B");
    check(fail && !bad_byte && !done, "R5 fail flags", {fail, bad_byte, done}, 3'b100);
    check(fail_addr == 3'd5, "R5 fail address", fail_addr, 5);
    check(int'(pulse_cnt) == MAXP, "R5 pulse count at limit", pulse_cnt, MAXP);
    check(arr[6] == 8'hFF && arr[7] == 8'hFF, "R5 later addresses untouched", {arr[6], arr[7]}, 16'hFFFF);

    // C: 0-to-1 request at address 3, address 2 needs nothing
    base_setup();
    init_img[3] = 8'h0F; image[3] = 8'h1F;
    push_pulses(0, 1); push_pulses(1, 1);
    run_once("C");
    check(fail && bad_byte && !done, "R6 bad byte flags", {fail, bad_byte, done}, 3'b110);
    check(fail_addr == 3'd3, "R6 fail address", fail_addr, 3);
    check(pulse_cnt == '0, "R6 no pulse spent", pulse_cnt, 0);
    check(arr[3] == 8'h0F && arr[4] == 8'hFF, "R6 contents untouched", {arr[3], arr[4]}, 16'h0FFF);
    check(arr[2] == 8'hFF, "R4 matching byte kept", arr[2], 8'hFF);

    // D: marginal cell at 6 only fails the normal-supply final read
    base_setup();
    weak_img[6] = 8'h10;
    push_pulses(0, 1); push_pulses(1, 1); push_pulses(3, 1); push_pulses(4, 1);
    push_pulses(5, 1); push_pulses(6, 1); push_pulses(7, 1);
    run_once("D");
    check(fail && !bad_byte && !done, "R8 final verify fail flags", {fail, bad_byte, done}, 3'b100);
    check(fail_addr == 3'd6, "R8 final verify fail address", fail_addr, 6);
    check(arr[7] == image[7], "R8 pulse phase completed first", arr[7], image[7]);

    // E: memory already holds the image
    base_setup();
    for (int i = 0; i < N; i++) init_img[i] = image[i];
    run_once("E");
    check(done && !fail, "R4 no pulses and done", {done, fail}, 2'b10);

    n_chk = n_chk + mon_chk;
    n_bad = n_bad + mon_bad;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule